// File: doc/BRIEF.md
# SONET/SDH Framing Word Aligner

This block sits behind a byte-wide deserializer whose byte boundaries fall at an arbitrary bit position in the line. Every cycle it slides a bit window over the most recent input bytes. It looks for the framing marker made of A1 bytes (0xF6) and A2 bytes (0x28) at each of the eight possible bit positions. When it finds the marker and alignment is permitted, it records that bit position. From then on it emits bytes cut at that position and raises a sync flag.

Control inputs choose between a short marker (one A1 then one A2) and a long marker (two A1 then two A2). A parameter can fix the block to the long marker for the highest line rate. A flip control mirrors the whole marker end for end before the comparison. Two further controls mirror the bit order of each byte on the way in and on the way out, so the block serves links that send either the most or the least significant bit of a byte first.

The search is manual. An enable input gates every new lock, and while it is low the recorded position is frozen.

Top module: `sdh_frame_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `sync_ok` low and `lock_ofs` zero.
- R2: With `long_sel` low, the window locks on the 16-bit marker 16'hF628, where the most significant bit is the earliest in time and din[7] is the earliest bit of a byte. The lock position is reported on `lock_ofs`. For a line delayed by s bits (din = {previous[s-1:0], current[7:s]}), the lock position is 0 for s = 0 and 8-s otherwise. `sync_ok` rises after the edge of the cycle in which the last marker bit is on `din`. If several positions match in one cycle, the lowest one is taken.
- R3: With `long_sel` high, only the 32-bit marker 32'hF6F62828 causes a lock. A lone F6,28 pair does not.
- R4: With `pat_flip` high, the marker is bit-reversed end for end before the comparison: 16'h146F in short mode and 32'h14146F6F in long mode. The unflipped marker then no longer locks.
- R5: With `in_rev` high, each input byte is bit-reversed before it enters the window. With `out_rev` high, each output byte is bit-reversed.
- R6: After the edge at which the lock occurs, `dout` holds the last marker byte. On each following edge it holds the next line byte, cut at the locked position. `sync_ok` then stays high until reset.
- R7: While `align_en` is low, `lock_ofs` and `sync_ok` keep their values, even when the marker appears at another position. Output bytes are still cut at the held position.
- R8: With parameter `FORCE_LONG` = 1, the 32-bit marker is always used and `long_sel` has no effect.
- R9: When `align_en` is high again, a marker at a new position moves `lock_ofs` to that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| align_en | input | 1 | Permits a new lock while high |
| long_sel | input | 1 | 0: short marker, 1: long marker |
| pat_flip | input | 1 | Mirrors the marker before comparison |
| in_rev | input | 1 | Mirrors the bits of each input byte |
| out_rev | input | 1 | Mirrors the bits of each output byte |
| din | input | 8 | Unaligned input byte |
| dout | output | 8 | Aligned output byte, meaningful while sync_ok is high |
| sync_ok | output | 1 | A lock has been taken since reset |
| lock_ofs | output | 3 | Locked bit position |

## Verification
The properties assume that `rst` is high for the first clock edge, so that every `$past` and `$rose` refers to reset state and never to unknown values. They also assume that `align_en` is a plain level that is only sampled at edges. The bench meets both conditions. It initialises `rst` high, and it changes `align_en`, the mode controls and `din` only one time unit after a rising edge. Mode controls are changed only in reset or between streams, so no stream sees its marker meaning change part way through.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;
   // lowest offset encoding width for a byte of the given size
   function automatic int ofs_bits(input int byte_w);
      return (byte_w <= 2) ? 1 : $clog2(byte_w);
   endfunction
endpackage

// File: rtl/sfa_window.sv
`timescale 1ns/1ps
// Bit window: current input byte plus the history needed for the long marker.
module sfa_window #(
   parameter int BYTE_W = 8,
   parameter int WIN_W  = 39
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_rev,
   input  logic [BYTE_W-1:0] din,
   output logic [WIN_W-1:0]  win
);
   localparam int HIST_W = WIN_W - BYTE_W;

   if (HIST_W <= BYTE_W) begin : g_bad_win
      $error("window must hold more than two bytes");
   end

   logic [BYTE_W-1:0] din_mir;
   logic [BYTE_W-1:0] cur;
   logic [HIST_W-1:0] hist_q;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_mir
      assign din_mir[b] = din[BYTE_W-1-b];
   end

   assign cur = in_rev ? din_mir : din;

   always_ff @(posedge clk) begin
      if (rst) hist_q <= '0;
      else     hist_q <= {hist_q[HIST_W-BYTE_W-1:0], cur};
   end

   assign win = {hist_q, cur};
endmodule

// File: rtl/sfa_matcher.sv
`timescale 1ns/1ps
// Parallel marker compare at every bit offset, lowest offset has priority.
module sfa_matcher #(
   parameter int              BYTE_W     = 8,
   parameter int              WIN_W      = 39,
   parameter int              OFS_W      = 3,
   parameter logic [BYTE_W-1:0] A1_CODE  = 8'hF6,
   parameter logic [BYTE_W-1:0] A2_CODE  = 8'h28,
   parameter bit              FORCE_LONG = 1'b0
) (
   input  logic [WIN_W-1:0] win,
   input  logic             long_sel,
   input  logic             pat_flip,
   output logic             any_hit,
   output logic [OFS_W-1:0] hit_ofs
);
   localparam int SHORT_W = 2 * BYTE_W;
   localparam int LONG_W  = 4 * BYTE_W;
   localparam logic [SHORT_W-1:0] BASE_S = {A1_CODE, A2_CODE};
   localparam logic [LONG_W-1:0]  BASE_L = {A1_CODE, A1_CODE, A2_CODE, A2_CODE};

   if (WIN_W != LONG_W + BYTE_W - 1) begin : g_bad_w
      $error("window width does not match the long marker");
   end

   logic [SHORT_W-1:0] mir_s, pat_s;
   logic [LONG_W-1:0]  mir_l, pat_l;
   logic [BYTE_W-1:0]  hit_s, hit_l, hits;
   logic               use_long;

   for (genvar b = 0; b < SHORT_W; b++) begin : g_mir_s
      assign mir_s[b] = BASE_S[SHORT_W-1-b];
   end
   for (genvar b = 0; b < LONG_W; b++) begin : g_mir_l
      assign mir_l[b] = BASE_L[LONG_W-1-b];
   end

   assign pat_s = pat_flip ? mir_s : BASE_S;
   assign pat_l = pat_flip ? mir_l : BASE_L;

   if (FORCE_LONG) begin : g_fixed_long
      assign use_long = long_sel | 1'b1;
   end else begin : g_sel_len
      assign use_long = long_sel;
   end

   for (genvar k = 0; k < BYTE_W; k++) begin : g_cmp
      assign hit_s[k] = (win[k +: SHORT_W] == pat_s);
      assign hit_l[k] = (win[k +: LONG_W]  == pat_l);
   end

   assign hits    = use_long ? hit_l : hit_s;
   assign any_hit = |hits;

   always_comb begin
      hit_ofs = '0;
      for (int i = BYTE_W - 1; i >= 0; i--) begin
         if (hits[i]) hit_ofs = OFS_W'(i);
      end
   end
endmodule

// File: rtl/sfa_lock.sv
`timescale 1ns/1ps
// Offset register, sync state and the output byte slicer.
module sfa_lock #(
   parameter int BYTE_W = 8,
   parameter int OFS_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              align_en,
   input  logic              any_hit,
   input  logic [OFS_W-1:0]  hit_ofs,
   input  logic              out_rev,
   input  logic [2*BYTE_W-2:0] tail,
   output logic [OFS_W-1:0]  lock_ofs,
   output logic              sync_ok,
   output logic [BYTE_W-1:0] dout
);
   logic              take;
   logic [OFS_W-1:0]  ofs_n, ofs_q;
   logic              sync_q;
   logic [BYTE_W-1:0] slice, slice_mir, dout_q;

   assign take  = align_en & any_hit;
   assign ofs_n = take ? hit_ofs : ofs_q;
   assign slice = tail[ofs_n +: BYTE_W];

   for (genvar b = 0; b < BYTE_W; b++) begin : g_mir
      assign slice_mir[b] = slice[BYTE_W-1-b];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ofs_q  <= '0;
         sync_q <= 1'b0;
         dout_q <= '0;
      end else begin
         ofs_q  <= ofs_n;
         sync_q <= sync_q | take;
         dout_q <= out_rev ? slice_mir : slice;
      end
   end

   assign lock_ofs = ofs_q;
   assign sync_ok  = sync_q;
   assign dout     = dout_q;
endmodule

// File: rtl/sdh_frame_aligner.sv
`timescale 1ns/1ps
module sdh_frame_aligner #(
   parameter int                BYTE_W     = 8,
   parameter logic [BYTE_W-1:0] A1_CODE    = 8'hF6,
   parameter logic [BYTE_W-1:0] A2_CODE    = 8'h28,
   parameter bit                FORCE_LONG = 1'b0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        align_en,
   input  logic        long_sel,
   input  logic        pat_flip,
   input  logic        in_rev,
   input  logic        out_rev,
   input  logic [7:0]  din,
   output logic [7:0]  dout,
   output logic        sync_ok,
   output logic [2:0]  lock_ofs
);
   localparam int OFS_W = sfa_pkg::ofs_bits(BYTE_W);
   localparam int WIN_W = 5 * BYTE_W - 1;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("port widths assume an 8-bit byte");
   end
   if (A1_CODE == A2_CODE) begin : g_bad_codes
      $error("A1 and A2 codes must differ");
   end

   logic [WIN_W-1:0] win;
   logic             any_hit;
   logic [OFS_W-1:0] hit_ofs;

   sfa_window #(.BYTE_W(BYTE_W), .WIN_W(WIN_W)) u_window (
      .clk(clk), .rst(rst), .in_rev(in_rev), .din(din), .win(win)
   );

   sfa_matcher #(
      .BYTE_W(BYTE_W), .WIN_W(WIN_W), .OFS_W(OFS_W),
      .A1_CODE(A1_CODE), .A2_CODE(A2_CODE), .FORCE_LONG(FORCE_LONG)
   ) u_matcher (
      .win(win), .long_sel(long_sel), .pat_flip(pat_flip),
      .any_hit(any_hit), .hit_ofs(hit_ofs)
   );

   sfa_lock #(.BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_lock (
      .clk(clk), .rst(rst), .align_en(align_en), .any_hit(any_hit),
      .hit_ofs(hit_ofs), .out_rev(out_rev), .tail(win[2*BYTE_W-2:0]),
      .lock_ofs(lock_ofs), .sync_ok(sync_ok), .dout(dout)
   );
endmodule

// File: rtl/sdh_frame_aligner_chk.sv
`timescale 1ns/1ps
module sdh_frame_aligner_chk (
   input logic       clk,
   input logic       rst,
   input logic       align_en,
   input logic       sync_ok,
   input logic [2:0] lock_ofs
);
   // R1: reset clears sync and offset
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!sync_ok && lock_ofs == 3'd0));

   // R6: sync stays up until reset
   p_sync_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      sync_ok |=> sync_ok);

   // R7: disabled search freezes offset and sync
   p_hold_when_off_r7: assert property (@(posedge clk) disable iff (rst)
      !align_en |=> ($stable(lock_ofs) && $stable(sync_ok)));

   // R7: a first lock needs the enable
   p_lock_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(sync_ok) |-> $past(align_en));

   // R9: the offset only moves through an enabled search
   p_ofs_move_en_r9: assert property (@(posedge clk) disable iff (rst)
      !$stable(lock_ofs) |-> $past(align_en));
endmodule

bind sdh_frame_aligner sdh_frame_aligner_chk u_chk (
   .clk(clk), .rst(rst), .align_en(align_en),
   .sync_ok(sync_ok), .lock_ofs(lock_ofs)
);

// File: tb/sdh_frame_aligner_bench.sv
`timescale 1ns/1ps
module sdh_frame_aligner_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       align_en = 1'b1, long_sel = 1'b0, pat_flip = 1'b0;
   logic       in_rev = 1'b0, out_rev = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout, dout_w;
   logic       sync_ok, sync_w;
   logic [2:0] lock_ofs, ofs_w;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] seq [16];
   logic [7:0] dn  [16];
   logic [7:0] dq  [16];
   logic       lk  [16];
   logic       lk2 [16];
   logic [2:0] of  [16];
   logic [2:0] of2 [16];

   always #10 clk = ~clk;

   sdh_frame_aligner u_sdh_frame_aligner (
      .clk(clk), .rst(rst), .align_en(align_en), .long_sel(long_sel),
      .pat_flip(pat_flip), .in_rev(in_rev), .out_rev(out_rev), .din(din),
      .dout(dout), .sync_ok(sync_ok), .lock_ofs(lock_ofs)
   );

   sdh_frame_aligner #(.FORCE_LONG(1'b1)) u_sdh_frame_aligner_long (
      .clk(clk), .rst(rst), .align_en(align_en), .long_sel(long_sel),
      .pat_flip(pat_flip), .in_rev(in_rev), .out_rev(out_rev), .din(din),
      .dout(dout_w), .sync_ok(sync_w), .lock_ofs(ofs_w)
   );

   function automatic logic [7:0] mir8(input logic [7:0] v);
      logic [7:0] r;
      for (int b = 0; b < 8; b++) r[b] = v[7-b];
      return r;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      din = 8'h00;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   // sends seq[0..n-1] delayed by s bits, records outputs after each edge
   task automatic stream(input int n, input int s);
      logic [15:0] acc = 16'h0000;
      for (int i = 0; i < n; i++) begin
         acc = {acc[7:0], seq[i]};
         din = acc[s +: 8];
         dn[i] = din;
         @(posedge clk);
         #1;
         dq[i] = dout; lk[i] = sync_ok; of[i] = lock_ofs;
         lk2[i] = sync_w; of2[i] = ofs_w;
      end
   endtask

   function automatic int first_lock(input int n, input bit wide);
      for (int i = 0; i < n; i++) if (wide ? lk2[i] : lk[i]) return i;
      return -1;
   endfunction

   task automatic load9(input logic [7:0] a, b, c, d, e, f, g, h, k);
      seq[0]=a; seq[1]=b; seq[2]=c; seq[3]=d; seq[4]=e;
      seq[5]=f; seq[6]=g; seq[7]=h; seq[8]=k;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "sync after reset", int'(sync_ok), 0);
      chk("R1", "offset after reset", int'(lock_ofs), 0);
   endtask

   task automatic t_short_shift(input int s);
      int li, exp_li;
      align_en = 1; long_sel = 0; pat_flip = 0; in_rev = 0; out_rev = 0;
      do_reset();
      load9(8'h00, 8'h00, 8'h00, 8'hF6, 8'h28, 8'h3C, 8'hA5, 8'h0F, 8'h81);
      stream(9, s);
      exp_li = (s == 0) ? 4 : 5;
      li = first_lock(9, 1'b0);
      chk("R2", $sformatf("lock cycle s=%0d", s), li, exp_li);
      if (li >= 0) begin
         chk("R2", $sformatf("lock_ofs s=%0d", s), int'(of[li]), (8 - s) % 8);
         chk("R6", $sformatf("first byte s=%0d", s), int'(dq[li]), 8'h28);
         chk("R6", $sformatf("next bytes s=%0d", s), int'({dq[li+1], dq[li+2], dq[li+3]}), 24'h3CA50F);
      end
      if (s == 0) chk("R8", "fixed-long ignores short marker", first_lock(9, 1'b1), -1);
   endtask

   task automatic t_long();
      int li;
      align_en = 1; long_sel = 1; pat_flip = 0; in_rev = 0; out_rev = 0;
      do_reset();
      load9(8'h00, 8'h00, 8'hF6, 8'h28, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(7, 0);
      chk("R3", "short marker in long mode", first_lock(7, 1'b0), -1);
      load9(8'h00, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h3C, 8'hA5, 8'h00, 8'h00);
      stream(7, 0);
      li = first_lock(7, 1'b0);
      chk("R3", "long marker lock cycle", li, 4);
      if (li >= 0) chk("R3", "long marker next byte", int'(dq[li+1]), 8'h3C);
      // R8: size select low, fixed-long instance still needs the long marker
      long_sel = 0;
      do_reset();
      load9(8'h00, 8'h00, 8'hF6, 8'h28, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(6, 0);
      chk("R8", "fixed-long after short marker", first_lock(6, 1'b1), -1);
      load9(8'h00, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h3C, 8'h00, 8'h00, 8'h00);
      stream(6, 0);
      chk("R8", "fixed-long lock cycle", first_lock(6, 1'b1), 4);
      chk("R8", "fixed-long offset", int'(of2[5]), 0);
   endtask

   task automatic t_flip();
      int li;
      align_en = 1; long_sel = 0; pat_flip = 1; in_rev = 0; out_rev = 0;
      do_reset();
      load9(8'h00, 8'hF6, 8'h28, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(5, 0);
      chk("R4", "plain marker with flip", first_lock(5, 1'b0), -1);
      load9(8'h00, 8'h14, 8'h6F, 8'h3C, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(5, 0);
      li = first_lock(5, 1'b0);
      chk("R4", "flipped marker lock", li, 2);
      if (li >= 0) chk("R4", "flipped first byte", int'(dq[li]), 8'h6F);
   endtask

   task automatic t_reverse();
      int li;
      align_en = 1; long_sel = 0; pat_flip = 0; in_rev = 1; out_rev = 1;
      do_reset();
      load9(8'h00, mir8(8'hF6), mir8(8'h28), 8'h3C, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(5, 0);
      li = first_lock(5, 1'b0);
      chk("R5", "lsb-first lock", li, 2);
      if (li >= 0) chk("R5", "in+out mirror restores byte", int'(dq[li+2]), 8'h01);
      in_rev = 0; out_rev = 1;
      do_reset();
      load9(8'h00, 8'hF6, 8'h28, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(5, 0);
      chk("R5", "out mirror first byte", int'(dq[2]), int'(mir8(8'h28)));
      chk("R5", "out mirror payload", int'(dq[3]), 8'h80);
   endtask

   task automatic t_hold();
      align_en = 0; long_sel = 0; pat_flip = 0; in_rev = 0; out_rev = 0;
      do_reset();
      load9(8'h00, 8'hF6, 8'h28, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      stream(5, 0);
      chk("R7", "no lock while disabled", first_lock(5, 1'b0), -1);
      align_en = 1;
      stream(4, 0);
      chk("R7", "lock after enable", first_lock(4, 1'b0), 2);
      align_en = 0;
      load9(8'h00, 8'h00, 8'hF6, 8'h28, 8'h3C, 8'hA5, 8'h00, 8'h00, 8'h00);
      stream(7, 3);
      chk("R7", "offset held", int'(of[6]), 0);
      chk("R7", "sync held", int'(lk[6]), 1);
      chk("R7", "bytes cut at held offset", int'(dq[4]), int'(dn[4]));
      align_en = 1;
      stream(7, 3);
      chk("R9", "relock offset", int'(of[4]), 5);
      chk("R9", "relock first byte", int'(dq[4]), 8'h28);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      for (int s = 0; s < 8; s++) t_short_shift(s);
      t_long();
      t_flip();
      t_reverse();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule